// File: doc/BRIEF.md
# Processor Bus Cycle Controller

This block is the bus-side sequencer of a processor core. The core hands it one transfer at a time: a read or a write, to memory or I/O space, carrying either data or code. The controller puts the transfer on the bus and keeps it there through wait states until the bus reports ready. A cacheable memory read can be widened into a line fill of several 64-bit beats when the system asserts the cache-enable input.

Two inputs take the bus away from the controller. The backoff input works at once: it aborts the cycle in flight, floats the bus in the same clock, and the aborted cycle starts again from its first beat once backoff is released. The hold request is gentler. The cycle in flight runs to completion, and only then is the bus floated and the hold acknowledged. A lock output covers both halves of a read-modify-write pair, and hold is refused while that pair is open.

Top module: `bus_cycle_ctl`

## Requirements
- R1: After reset the controller is idle: `req_ready`=1, `bus_busy`=0, `hold_ack`=0, `bus_lock`=0, `drive_en`=1.
- R2: A request is taken at a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle `bus_busy`=1, `bus_mem`=NOT `req_io`, `bus_wr`=`req_write` and `bus_data`=`req_data`.
- R3: A beat ends only in a cycle where `rdy_n`=0 (and `backoff_n`=1); every cycle with `rdy_n`=1 is a wait state in which the cycle-type outputs hold steady. `cyc_done` is 1 in the cycle of the last beat's ready, and `bus_busy` is 0 in the following cycle.
- R4: If `cache_en_n`=0 in the cycle where the first beat of a memory read (`req_io`=0, `req_write`=0) is readied, the cycle becomes a fill of LINE_BEATS beats. Beat k puts out `bus_addr` with its low log2(LINE_BEATS) bits equal to (start + k) mod LINE_BEATS and its upper bits unchanged. `cyc_done` rises only on the last beat. `cache_en_n` has no effect on writes, on I/O reads and on later beats.
- R5: While `backoff_n`=0, `drive_en`=0 and `beat_ack`=0 in that same cycle, whatever `rdy_n` is. After `backoff_n` is sampled high again, the aborted cycle is back on the bus one cycle later from its first beat (start address, fill not yet decided).
- R6: A hold request is granted at the first clock edge where the controller is idle and no locked pair is open. While a cycle is in flight, that cycle completes first. From the edge after grant, `hold_ack`=1 and `drive_en`=0. While `hold_req` is pending and grantable, `req_ready`=0.
- R7: One cycle after `hold_req` is sampled low, `hold_ack`=0 and `drive_en`=1.
- R8: A read requested with `req_lock`=1 raises `bus_lock` from its first bus cycle. `bus_lock` stays 1 until the cycle after the following write's `cyc_done`. Between the two halves, hold is not granted.
- R9: `req_ready` is 0 while a cycle is on the bus, during hold and during backoff; `req_valid` in those cycles starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core has a transfer to issue |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_data | input | 1 | 1 = data, 0 = code |
| req_lock | input | 1 | Transfer belongs to a locked read-modify-write pair |
| req_addr | input | ADDR_W | Beat (8-byte) address of the transfer |
| req_ready | output | 1 | Controller can take a request this cycle |
| beat_ack | output | 1 | A beat completes this cycle |
| cyc_done | output | 1 | Whole transfer completes this cycle |
| bus_addr | output | ADDR_W | Address of the current beat |
| bus_busy | output | 1 | A bus cycle is being driven |
| bus_mem | output | 1 | 1 = memory cycle, 0 = I/O cycle |
| bus_wr | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_data | output | 1 | 1 = data cycle, 0 = code cycle |
| bus_lock | output | 1 | Locked sequence in progress |
| drive_en | output | 1 | 1 = controller drives the bus, 0 = floated |
| hold_ack | output | 1 | Bus handed to another master |
| rdy_n | input | 1 | Active-low bus ready |
| backoff_n | input | 1 | Active-low abort-and-float request |
| cache_en_n | input | 1 | Active-low cacheability / line-fill enable |
| hold_req | input | 1 | Another master asks for the bus |

## Verification
A taken request shows on the bus one clock after the accepting edge. `beat_ack`, `cyc_done` and the floating of the bus under backoff are combinational on the inputs of the same cycle. The bench therefore drives a cycle's inputs just after a rising edge and samples one time unit later, before the next edge. Hold grant and hold release are registered and are checked one edge after the idle or release condition. A resumed cycle is checked one edge after backoff is seen high. The sweep covers every cycle type, every cache-enable setting and zero to two wait states per beat, with start addresses that walk the wrap point of the line.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUSY = 2'd1,
      ST_BOFF = 2'd2,
      ST_HOLD = 2'd3
   } bcc_state_e;

   typedef struct packed {
      logic wr;
      logic io;
      logic data;
      logic lock;
   } bcc_kind_t;

   function automatic logic bcc_cacheable(input bcc_kind_t k);
      return !k.io && !k.wr;
   endfunction

endpackage

// File: rtl/bcc_beat_seq.sv
module bcc_beat_seq #(
   parameter int ADDR_W     = 29,
   parameter int LINE_BEATS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic              abort,
   input  logic              beat_ack,
   input  logic              fill_ok,
   output logic [ADDR_W-1:0] beat_addr,
   output logic              last_beat
);
   localparam int BW = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1;

   logic [ADDR_W-1:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    base_q <= '0;
      else if (load) base_q <= base_addr;
   end

   generate
      if (LINE_BEATS == 1) begin : g_single
         assign beat_addr = base_q;
         assign last_beat = 1'b1;
      end else begin : g_fill
         localparam logic [BW-1:0] LAST = BW'(LINE_BEATS - 1);
         logic [BW-1:0] beat_q;
         logic          fill_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               beat_q <= '0;
               fill_q <= 1'b0;
            end else if (load || abort) begin
               beat_q <= '0;
               fill_q <= 1'b0;
            end else if (beat_ack) begin
               if (last_beat) begin
                  beat_q <= '0;
                  fill_q <= 1'b0;
               end else begin
                  beat_q <= beat_q + 1'b1;
                  fill_q <= 1'b1;
               end
            end
         end

         assign last_beat = fill_q ? (beat_q == LAST) : !fill_ok;
         assign beat_addr = {base_q[ADDR_W-1:BW], base_q[BW-1:0] + beat_q};
      end
   endgenerate

endmodule

// File: rtl/bcc_lock_trk.sv
module bcc_lock_trk (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_done,
   input  logic cyc_live,
   input  logic cur_lock,
   input  logic cur_wr,
   output logic lock_pend,
   output logic lock_out
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           lock_pend <= 1'b0;
      else if (cyc_done && cur_wr)          lock_pend <= 1'b0;
      else if (cyc_done && cur_lock)        lock_pend <= 1'b1;
   end

   assign lock_out = lock_pend || (cyc_live && cur_lock);

endmodule

// File: rtl/bus_cycle_ctl.sv
module bus_cycle_ctl
   import bcc_pkg::*;
#(
   parameter int ADDR_W     = 29,
   parameter int LINE_BEATS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_io,
   input  logic              req_data,
   input  logic              req_lock,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              beat_ack,
   output logic              cyc_done,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_busy,
   output logic              bus_mem,
   output logic              bus_wr,
   output logic              bus_data,
   output logic              bus_lock,
   output logic              drive_en,
   output logic              hold_ack,
   input  logic              rdy_n,
   input  logic              backoff_n,
   input  logic              cache_en_n,
   input  logic              hold_req
);
   localparam int BW = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1;

   generate
      if ((LINE_BEATS < 1) || ((LINE_BEATS & (LINE_BEATS - 1)) != 0)) begin : g_bad_beats
         $error("LINE_BEATS must be a power of two");
      end
      if (ADDR_W <= BW) begin : g_bad_addr
         $error("ADDR_W must exceed the beat index width");
      end
   endgenerate

   bcc_state_e state_q, state_d;
   bcc_kind_t  kind_q;
   logic       resume_q;
   logic       lock_pend;
   logic       last_beat;
   logic       accept;
   logic       boff;
   logic       fill_ok;
   logic       abort;
   logic       hold_grantable;

   assign boff           = !backoff_n;
   assign hold_grantable = hold_req && !lock_pend;
   assign req_ready      = (state_q == ST_IDLE) && !boff && !hold_grantable;
   assign accept         = req_valid && req_ready;
   assign bus_busy       = (state_q == ST_BUSY) && !boff;
   assign beat_ack       = bus_busy && !rdy_n;
   assign cyc_done       = beat_ack && last_beat;
   assign abort          = (state_q == ST_BUSY) && boff;
   assign fill_ok        = bcc_cacheable(kind_q) && !cache_en_n;
   assign hold_ack       = (state_q == ST_HOLD);
   assign drive_en       = !boff && (state_q != ST_BOFF) && (state_q != ST_HOLD);

   assign bus_mem  = !kind_q.io;
   assign bus_wr   = kind_q.wr;
   assign bus_data = kind_q.data;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (boff)                state_d = ST_BOFF;
            else if (hold_grantable) state_d = ST_HOLD;
            else if (accept)         state_d = ST_BUSY;
         end
         ST_BUSY: begin
            if (boff)          state_d = ST_BOFF;
            else if (cyc_done) state_d = ST_IDLE;
         end
         ST_BOFF: begin
            if (!boff) state_d = resume_q ? ST_BUSY : ST_IDLE;
         end
         ST_HOLD: begin
            if (!hold_req) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         kind_q   <= '0;
         resume_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            kind_q.wr   <= req_write;
            kind_q.io   <= req_io;
            kind_q.data <= req_data;
            kind_q.lock <= req_lock;
         end
         if (abort)                          resume_q <= 1'b1;
         else if (state_q == ST_BOFF && !boff) resume_q <= 1'b0;
      end
   end

   bcc_beat_seq #(
      .ADDR_W     (ADDR_W),
      .LINE_BEATS (LINE_BEATS)
   ) u_beat (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .base_addr (req_addr),
      .abort     (abort),
      .beat_ack  (beat_ack),
      .fill_ok   (fill_ok),
      .beat_addr (bus_addr),
      .last_beat (last_beat)
   );

   bcc_lock_trk u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .cyc_done  (cyc_done),
      .cyc_live  ((state_q == ST_BUSY) || (state_q == ST_BOFF && resume_q)),
      .cur_lock  (kind_q.lock),
      .cur_wr    (kind_q.wr),
      .lock_pend (lock_pend),
      .lock_out  (bus_lock)
   );

endmodule

// File: rtl/bcc_chk.sv
module bcc_chk #(
   parameter int ADDR_W = 29
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              beat_ack,
   input logic              cyc_done,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_busy,
   input logic              bus_mem,
   input logic              bus_wr,
   input logic              bus_data,
   input logic              bus_lock,
   input logic              drive_en,
   input logic              hold_ack,
   input logic              rdy_n,
   input logic              backoff_n,
   input logic              hold_req
);
   // R2: a taken request is on the bus next cycle unless backoff intervenes
   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> bus_busy || !backoff_n);

   // R3: completion only with ready sampled asserted
   p_done_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done |-> !rdy_n && backoff_n);

   // R3: bus goes quiet after the last beat
   p_done_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done |=> !bus_busy);

   // R3: cycle type steady through wait states
   p_type_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_busy && $past(bus_busy) && !$past(cyc_done) |-> $stable({bus_mem, bus_wr, bus_data}));

   // R5: nothing completes and the bus floats under backoff
   p_boff_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !backoff_n |-> !drive_en && !beat_ack && !bus_busy);

   // R6: bus released and idle while hold is acknowledged
   p_hold_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack |-> !drive_en && !bus_busy && !req_ready);

   // R7: hold acknowledge drops one cycle after the request goes away
   p_hold_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack && !hold_req |=> !hold_ack);

   // R8: no hold inside a locked pair
   p_hold_nolock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack |-> !bus_lock);

   // R8: lock ends only after a write completes
   p_lock_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_lock) |-> $past(cyc_done && bus_wr));

endmodule

bind bus_cycle_ctl bcc_chk #(.ADDR_W(ADDR_W)) u_bcc_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .beat_ack  (beat_ack),
   .cyc_done  (cyc_done),
   .bus_addr  (bus_addr),
   .bus_busy  (bus_busy),
   .bus_mem   (bus_mem),
   .bus_wr    (bus_wr),
   .bus_data  (bus_data),
   .bus_lock  (bus_lock),
   .drive_en  (drive_en),
   .hold_ack  (hold_ack),
   .rdy_n     (rdy_n),
   .backoff_n (backoff_n),
   .hold_req  (hold_req)
);

// File: tb/tb_bus_cycle_ctl.sv
`timescale 1ns/1ps
module tb_bus_cycle_ctl;
   localparam int AW    = 16;
   localparam int BEATS = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0, req_data = 1'b0, req_lock = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_ready, beat_ack, cyc_done;
   logic [AW-1:0] bus_addr;
   logic          bus_busy, bus_mem, bus_wr, bus_data, bus_lock, drive_en, hold_ack;
   logic          rdy_n = 1'b1, backoff_n = 1'b1, cache_en_n = 1'b1, hold_req = 1'b0;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   bus_cycle_ctl #(.ADDR_W(AW), .LINE_BEATS(BEATS)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_io(req_io),
      .req_data(req_data), .req_lock(req_lock), .req_addr(req_addr),
      .req_ready(req_ready), .beat_ack(beat_ack), .cyc_done(cyc_done),
      .bus_addr(bus_addr), .bus_busy(bus_busy), .bus_mem(bus_mem),
      .bus_wr(bus_wr), .bus_data(bus_data), .bus_lock(bus_lock),
      .drive_en(drive_en), .hold_ack(hold_ack),
      .rdy_n(rdy_n), .backoff_n(backoff_n), .cache_en_n(cache_en_n), .hold_req(hold_req)
   );

   task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [AW-1:0] beat_of(input logic [AW-1:0] a, input int k);
      logic [1:0] lo;
      lo = a[1:0] + 2'(k);
      return {a[AW-1:2], lo};
   endfunction

   // Issue one transfer and walk it to completion
   task automatic run_cycle(input bit io, input bit wr, input bit dc, input bit ken_n,
                            input int waits, input logic [AW-1:0] a, input bit lk);
      int nb;
      nb = (!io && !wr && !ken_n) ? BEATS : 1;
      req_valid = 1'b1; req_io = io; req_write = wr; req_data = dc;
      req_lock = lk; req_addr = a;
      #1;
      chk("R9", "req_ready before issue", req_ready, 1);
      tick();
      req_valid = 1'b0;
      for (int b = 0; b < nb; b++) begin
         for (int w = 0; w < waits; w++) begin
            rdy_n = 1'b1; cache_en_n = ken_n;
            #1;
            chk("R3", "busy in wait state", bus_busy, 1);
            chk("R3", "no done in wait state", cyc_done, 0);
            chk("R2", "cycle type", {bus_mem, bus_wr, bus_data}, {!io, wr, dc});
            chk("R8", "lock during cycle", bus_lock, lk);
            tick();
         end
         rdy_n = 1'b0;
         cache_en_n = (b == 0) ? ken_n : 1'b1;
         #1;
         chk("R4", "beat address", bus_addr, beat_of(a, b));
         chk("R4", "done on last beat only", cyc_done, (b == nb - 1));
         chk("R3", "beat ack with ready", beat_ack, 1);
         tick();
      end
      rdy_n = 1'b1; cache_en_n = 1'b1;
      #1;
      chk("R3", "busy clear after done", bus_busy, 0);
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog (all requirements): actual hung, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] a;
      int it;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1", "req_ready", req_ready, 1);
      chk("R1", "bus_busy", bus_busy, 0);
      chk("R1", "hold_ack", hold_ack, 0);
      chk("R1", "bus_lock", bus_lock, 0);
      chk("R1", "drive_en", drive_en, 1);
      rst_n = 1'b1;
      tick();
      chk("R1", "idle after reset", req_ready, 1);

      // R2 R3 R4: sweep of cycle types, cache enable and wait states
      it = 0;
      for (int io = 0; io < 2; io++)
         for (int wr = 0; wr < 2; wr++)
            for (int dc = 0; dc < 2; dc++)
               for (int ken = 0; ken < 2; ken++)
                  for (int w = 0; w < 3; w++) begin
                     a = AW'(16'h1230 + it * 7);
                     run_cycle(io[0], wr[0], dc[0], ken[0], w, a, 1'b0);
                     tick();
                     it++;
                  end

      // R5: backoff in the middle of a line fill, then restart from beat 0
      a = 16'h0402;
      req_valid = 1'b1; req_io = 1'b0; req_write = 1'b0; req_data = 1'b1;
      req_lock = 1'b0; req_addr = a;
      tick();
      req_valid = 1'b0;
      for (int b = 0; b < 2; b++) begin
         rdy_n = 1'b0; cache_en_n = 1'b0;
         tick();
      end
      backoff_n = 1'b0; rdy_n = 1'b0;
      #1;
      chk("R5", "float at backoff", drive_en, 0);
      chk("R5", "ready ignored under backoff", beat_ack, 0);
      chk("R5", "no done under backoff", cyc_done, 0);
      tick();
      chk("R5", "still floated", drive_en, 0);
      chk("R9", "no request during backoff", req_ready, 0);
      tick();
      backoff_n = 1'b1; rdy_n = 1'b1;
      tick();
      chk("R5", "cycle resumed", bus_busy, 1);
      chk("R5", "driving again", drive_en, 1);
      chk("R5", "restart at first beat", bus_addr, a);
      for (int b = 0; b < BEATS; b++) begin
         rdy_n = 1'b0; cache_en_n = (b == 0) ? 1'b0 : 1'b1;
         #1;
         chk("R5", "replayed beat address", bus_addr, beat_of(a, b));
         chk("R5", "replayed done", cyc_done, (b == BEATS - 1));
         tick();
      end
      rdy_n = 1'b1; cache_en_n = 1'b1;
      tick();

      // R5: backoff while idle
      backoff_n = 1'b0;
      #1;
      chk("R5", "idle float", drive_en, 0);
      tick();
      backoff_n = 1'b1;
      tick();
      chk("R5", "idle after idle backoff", req_ready, 1);
      chk("R5", "nothing resumed", bus_busy, 0);

      // R6 R7: hold arriving during a write with wait states
      req_valid = 1'b1; req_io = 1'b0; req_write = 1'b1; req_data = 1'b1;
      req_lock = 1'b0; req_addr = 16'h0040;
      tick();
      req_valid = 1'b0;
      hold_req = 1'b1; rdy_n = 1'b1;
      #1;
      chk("R6", "no ack while busy", hold_ack, 0);
      chk("R6", "still driving while busy", drive_en, 1);
      tick();
      rdy_n = 1'b0;
      #1;
      chk("R6", "cycle completes first", cyc_done, 1);
      tick();
      rdy_n = 1'b1;
      req_valid = 1'b1;
      #1;
      chk("R6", "request blocked by hold", req_ready, 0);
      chk("R6", "ack not yet", hold_ack, 0);
      tick();
      chk("R6", "hold granted", hold_ack, 1);
      chk("R6", "bus floated on hold", drive_en, 0);
      tick();
      chk("R9", "request ignored during hold", bus_busy, 0);
      req_valid = 1'b0;
      hold_req = 1'b0;
      tick();
      chk("R7", "ack dropped", hold_ack, 0);
      chk("R7", "driving after release", drive_en, 1);
      tick();
      chk("R9", "no stray cycle", bus_busy, 0);

      // R8: locked read then write, hold refused in between
      run_cycle(1'b0, 1'b0, 1'b1, 1'b1, 1, 16'h0100, 1'b1);
      hold_req = 1'b1;
      for (int k = 0; k < 3; k++) begin
         tick();
         chk("R8", "no hold inside lock", hold_ack, 0);
         chk("R8", "lock held between halves", bus_lock, 1);
      end
      run_cycle(1'b0, 1'b1, 1'b1, 1'b1, 0, 16'h0100, 1'b1);
      chk("R8", "lock released after write", bus_lock, 0);
      tick();
      chk("R8", "hold granted after pair", hold_ack, 1);
      hold_req = 1'b0;
      tick();
      chk("R7", "hold released", hold_ack, 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule